// File: doc/BRIEF.md
# 64-bit Execute-Stage Integer ALU with Shift-and-Add Address Generation

This block is the purely combinational arithmetic unit that sits in the execute stage of a 64-bit in-order integer pipeline. It takes two 64-bit operands and a 5-bit operation code. It returns a 64-bit result, a flag for an all-zero result, and the signed and unsigned less-than relations of the two operands. These outputs let a branch resolve in the same stage as the arithmetic. The pipeline chooses the operands (register, immediate or program counter) before they reach the block.

The block implements the full-width operations: add, subtract, AND, OR, XOR, the three shifts and the two set-less-than forms. It also implements the 32-bit word variants, whose results are sign-extended from bit 31. The same adder serves an address-generation family. That family scales the first operand by 2, 4 or 8 and adds the second operand. It has forms that first zero-extend the low 32 bits of the first operand, and a plain zero-extend-then-add. No second adder exists for these operations.

Top module: `exu_alu`

## Requirements
- R1: Operation codes are: 0 ADD, 1 SUB, 2 AND, 3 OR, 4 XOR, 5 SHL, 6 SHR, 7 SHRA, 8 LTS, 9 LTU, 10 ADD32, 11 SUB32, 12 SHL32, 13 SHR32, 14 SHRA32, 15 SCL1, 16 SCL2, 17 SCL3, 18 SCL1Z, 19 SCL2Z, 20 SCL3Z, 21 ADDZ. ADD and SUB return a+b and a-b modulo 2^64.
- R2: AND, OR and XOR return the bitwise combination of a and b.
- R3: SHL, SHR and SHRA shift a by b[5:0]. SHR fills with zeros and SHRA fills with copies of a[63]. A shift amount of 0 returns a unchanged.
- R4: ADD32 and SUB32 compute on a[31:0] and b[31:0]. Bit 31 of the 32-bit result fills result bits 63:32.
- R5: SHL32, SHR32 and SHRA32 shift a[31:0] by b[4:0] and ignore b[5]. SHRA32 fills with a[31]. The 32-bit result is sign-extended to 64 bits.
- R6: lt_s_o and lt_u_o give the signed and unsigned a<b for every operation code. LTS and LTU return that relation as 0 or 1 in result bit 0, with all other bits zero.
- R7: SCL1, SCL2 and SCL3 return (a shifted left by 1, 2 or 3) + b, modulo 2^64.
- R8: SCL1Z, SCL2Z and SCL3Z zero-extend a[31:0], shift that value left by 1, 2 or 3 and add b. ADDZ returns the zero-extended a[31:0] + b.
- R9: zero_o is 1 exactly when the 64-bit result is zero.
- R10: The unused operation codes 22 to 31 give a result of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand, or shift amount in the low bits |
| op_i | input | 5 | Operation code (see R1) |
| res_o | output | 64 | Result |
| zero_o | output | 1 | High when res_o is all zeros |
| lt_s_o | output | 1 | Signed a_i < b_i |
| lt_u_o | output | 1 | Unsigned a_i < b_i |

## Verification
Every output of this block is combinational, so each result is due in the same cycle that its operands and code are applied, with no register on the path. The bench applies each stimulus just after a rising edge and compares all four outputs at the following falling edge. By then the inputs have been stable for half a period. The bench sweeps every operation code across the full cross product of corner values: zero, all-ones, the sign-boundary patterns at bits 31 and 63, and shift amounts at 0, 31, 32, 63 and 64. It then repeats the sweep with random operand pairs, checking each output against arithmetic written independently in the bench.

// File: rtl/exu_alu_pkg.sv
package exu_alu_pkg;

    localparam int OPW = 5;

    typedef enum logic [OPW-1:0] {
        OP_ADD    = 5'd0,
        OP_SUB    = 5'd1,
        OP_AND    = 5'd2,
        OP_OR     = 5'd3,
        OP_XOR    = 5'd4,
        OP_SHL    = 5'd5,
        OP_SHR    = 5'd6,
        OP_SHRA   = 5'd7,
        OP_LTS    = 5'd8,
        OP_LTU    = 5'd9,
        OP_ADD32  = 5'd10,
        OP_SUB32  = 5'd11,
        OP_SHL32  = 5'd12,
        OP_SHR32  = 5'd13,
        OP_SHRA32 = 5'd14,
        OP_SCL1   = 5'd15,
        OP_SCL2   = 5'd16,
        OP_SCL3   = 5'd17,
        OP_SCL1Z  = 5'd18,
        OP_SCL2Z  = 5'd19,
        OP_SCL3Z  = 5'd20,
        OP_ADDZ   = 5'd21
    } alu_op_e;

endpackage

// File: rtl/exu_alu_adder.sv
// Single shared adder: plain add/sub plus scaled and zero-extended addends.
module exu_alu_adder #(
    parameter int W = 64
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [1:0]   scale_i,
    input  logic         zext_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o
);
    localparam int HW = W / 2;

    logic [W-1:0] a_ext;
    logic [W-1:0] a_scaled;
    logic [W-1:0] b_eff;

    always_comb begin
        a_ext    = zext_i ? {{HW{1'b0}}, a_i[HW-1:0]} : a_i;
        a_scaled = a_ext << scale_i;
        b_eff    = sub_i ? ~b_i : b_i;
        sum_o    = a_scaled + b_eff + {{(W-1){1'b0}}, sub_i};
    end

    // R7: with a zero second operand the sum is just the scaled first operand
    always_comb begin
        if (!sub_i && b_i == '0 && !zext_i)
            assert_scale_only_R7: assert (sum_o == (a_i << scale_i));
    end
endmodule

// File: rtl/exu_alu_shifter.sv
// Logarithmic right shifter; left shifts go through bit reversal.
module exu_alu_shifter #(
    parameter int W = 64
) (
    input  logic [W-1:0]         din_i,
    input  logic [$clog2(W)-1:0] amt_i,
    input  logic                 left_i,
    input  logic                 arith_i,
    output logic [W-1:0]         dout_o
);
    localparam int SHW = $clog2(W);

    logic [W-1:0] rev_in;
    logic [W-1:0] rev_out;
    logic         fill;
    logic [W-1:0] stage [SHW+1];

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_rev
            assign rev_in[gi] = din_i[W-1-gi];
        end
    endgenerate

    assign fill     = arith_i & ~left_i & din_i[W-1];
    assign stage[0] = left_i ? rev_in : din_i;

    genvar gs;
    generate
        for (gs = 0; gs < SHW; gs++) begin : g_stage
            localparam int D = 1 << gs;
            assign stage[gs+1] = amt_i[gs] ? {{D{fill}}, stage[gs][W-1:D]}
                                           : stage[gs];
        end
        for (gi = 0; gi < W; gi++) begin : g_unrev
            assign rev_out[gi] = stage[SHW][W-1-gi];
        end
    endgenerate

    assign dout_o = left_i ? rev_out : stage[SHW];

    // R3: a zero shift amount passes the operand through in every mode
    always_comb begin
        if (amt_i == '0)
            assert_zero_shift_R3: assert (dout_o == din_i);
    end
endmodule

// File: rtl/exu_alu_compare.sv
// Operand relations for branch resolution, independent of the operation.
module exu_alu_compare #(
    parameter int W = 64
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         lt_s_o,
    output logic         lt_u_o
);
    always_comb begin
        lt_u_o = a_i < b_i;
        lt_s_o = (a_i[W-1] != b_i[W-1]) ? a_i[W-1] : lt_u_o;
    end

    // R6: equal operands are never less-than in either sense
    always_comb begin
        if (a_i == b_i)
            assert_equal_not_less_R6: assert (!lt_s_o && !lt_u_o);
    end
endmodule

// File: rtl/exu_alu.sv
module exu_alu
    import exu_alu_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  logic [OPW-1:0] op_i,
    output logic [W-1:0]   res_o,
    output logic           zero_o,
    output logic           lt_s_o,
    output logic           lt_u_o
);
    localparam int HW  = W / 2;
    localparam int SHW = $clog2(W);

    alu_op_e        op;
    logic [1:0]     scale;
    logic           zext, sub;
    logic [W-1:0]   sum;
    logic [W-1:0]   sh_in, sh_out;
    logic [SHW-1:0] sh_amt;
    logic           sh_left, sh_arith, word_op;
    logic [W-1:0]   word_src;

    assign op = alu_op_e'(op_i);

    // adder control
    always_comb begin
        scale = 2'd0;
        zext  = 1'b0;
        sub   = 1'b0;
        unique case (op)
            OP_SUB, OP_SUB32: sub = 1'b1;
            OP_SCL1:          scale = 2'd1;
            OP_SCL2:          scale = 2'd2;
            OP_SCL3:          scale = 2'd3;
            OP_SCL1Z:         begin scale = 2'd1; zext = 1'b1; end
            OP_SCL2Z:         begin scale = 2'd2; zext = 1'b1; end
            OP_SCL3Z:         begin scale = 2'd3; zext = 1'b1; end
            OP_ADDZ:          zext = 1'b1;
            default:          ;
        endcase
    end

    // shifter control
    always_comb begin
        word_op  = (op == OP_SHL32) || (op == OP_SHR32) || (op == OP_SHRA32);
        sh_left  = (op == OP_SHL) || (op == OP_SHL32);
        sh_arith = (op == OP_SHRA) || (op == OP_SHRA32);
        sh_amt   = word_op ? {1'b0, b_i[SHW-2:0]} : b_i[SHW-1:0];
        unique case (op)
            OP_SHR32:  sh_in = {{HW{1'b0}}, a_i[HW-1:0]};
            OP_SHRA32: sh_in = {{HW{a_i[HW-1]}}, a_i[HW-1:0]};
            default:   sh_in = a_i;
        endcase
    end

    exu_alu_adder #(.W(W)) u_adder (
        .a_i(a_i), .b_i(b_i), .scale_i(scale), .zext_i(zext),
        .sub_i(sub), .sum_o(sum)
    );

    exu_alu_shifter #(.W(W)) u_shift (
        .din_i(sh_in), .amt_i(sh_amt), .left_i(sh_left),
        .arith_i(sh_arith), .dout_o(sh_out)
    );

    exu_alu_compare #(.W(W)) u_cmp (
        .a_i(a_i), .b_i(b_i), .lt_s_o(lt_s_o), .lt_u_o(lt_u_o)
    );

    // result select
    always_comb begin
        word_src = (op == OP_ADD32 || op == OP_SUB32) ? sum : sh_out;
        unique case (op)
            OP_ADD, OP_SUB, OP_SCL1, OP_SCL2, OP_SCL3,
            OP_SCL1Z, OP_SCL2Z, OP_SCL3Z, OP_ADDZ:
                res_o = sum;
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_SHL, OP_SHR, OP_SHRA:
                res_o = sh_out;
            OP_LTS:  res_o = {{(W-1){1'b0}}, lt_s_o};
            OP_LTU:  res_o = {{(W-1){1'b0}}, lt_u_o};
            OP_ADD32, OP_SUB32, OP_SHL32, OP_SHR32, OP_SHRA32:
                res_o = {{HW{word_src[HW-1]}}, word_src[HW-1:0]};
            default: res_o = '0;
        endcase
        zero_o = (res_o == '0);
    end

    // R4/R5: word operations leave a sign-extended result
    always_comb begin
        if (op == OP_ADD32 || op == OP_SUB32 || op == OP_SHL32 ||
            op == OP_SHR32 || op == OP_SHRA32)
            assert_word_sext_R4: assert (res_o[W-1:HW] == {HW{res_o[HW-1]}});
    end

    // R8: zero-extended add with zero second operand has clear upper half
    always_comb begin
        if (op == OP_ADDZ && b_i == '0)
            assert_addz_upper_R8: assert (res_o[W-1:HW] == '0);
    end

    // R6: same sign bits make the signed and unsigned relations agree
    always_comb begin
        if (a_i[W-1] == b_i[W-1])
            assert_lt_agree_R6: assert (lt_s_o == lt_u_o);
    end
endmodule

// File: tb/tb_exu_alu.sv
module tb_exu_alu;
    logic        clk = 1'b0;
    logic [63:0] a, b, res;
    logic [4:0]  op;
    logic        zero, lts, ltu;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    exu_alu dut (
        .a_i(a), .b_i(b), .op_i(op),
        .res_o(res), .zero_o(zero), .lt_s_o(lts), .lt_u_o(ltu)
    );

    function automatic logic [63:0] sx32(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    function automatic logic [63:0] model(input logic [4:0] o,
                                          input logic [63:0] x,
                                          input logic [63:0] y);
        logic [63:0] zx;
        zx = {32'd0, x[31:0]};
        case (o)
            5'd0:  return x + y;
            5'd1:  return x - y;
            5'd2:  return x & y;
            5'd3:  return x | y;
            5'd4:  return x ^ y;
            5'd5:  return x << y[5:0];
            5'd6:  return x >> y[5:0];
            5'd7:  return $unsigned($signed(x) >>> y[5:0]);
            5'd8:  return {63'd0, $signed(x) < $signed(y)};
            5'd9:  return {63'd0, x < y};
            5'd10: return sx32(x[31:0] + y[31:0]);
            5'd11: return sx32(x[31:0] - y[31:0]);
            5'd12: return sx32(x[31:0] << y[4:0]);
            5'd13: return sx32(x[31:0] >> y[4:0]);
            5'd14: return sx32($unsigned($signed(x[31:0]) >>> y[4:0]));
            5'd15: return x * 64'd2 + y;
            5'd16: return x * 64'd4 + y;
            5'd17: return x * 64'd8 + y;
            5'd18: return zx * 64'd2 + y;
            5'd19: return zx * 64'd4 + y;
            5'd20: return zx * 64'd8 + y;
            5'd21: return zx + y;
            default: return 64'd0;
        endcase
    endfunction

    function automatic string req_of(input logic [4:0] o);
        if (o <= 5'd1)  return "R1";
        if (o <= 5'd4)  return "R2";
        if (o <= 5'd7)  return "R3";
        if (o <= 5'd9)  return "R6";
        if (o <= 5'd11) return "R4";
        if (o <= 5'd14) return "R5";
        if (o <= 5'd17) return "R7";
        if (o <= 5'd21) return "R8";
        return "R10";
    endfunction

    task automatic apply(input logic [4:0] o, input logic [63:0] x,
                         input logic [63:0] y);
        logic [63:0] exp;
        @(posedge clk);
        op = o; a = x; b = y;
        @(negedge clk);
        exp = model(o, x, y);
        n_chk++;
        if (res !== exp) begin
            n_bad++;
            $display("FAIL %s op=%0d a=%h b=%h res actual=%h expected=%h",
                     req_of(o), o, x, y, res, exp);
        end
        n_chk++;
        if (zero !== (exp == 64'd0)) begin
            n_bad++;
            $display("FAIL R9 op=%0d zero actual=%b expected=%b", o, zero, exp == 64'd0);
        end
        n_chk++;
        if (lts !== ($signed(x) < $signed(y)) || ltu !== (x < y)) begin
            n_bad++;
            $display("FAIL R6 op=%0d lt_s/lt_u actual=%b%b expected=%b%b",
                     o, lts, ltu, $signed(x) < $signed(y), x < y);
        end
    endtask

    logic [63:0] corners [10] = '{
        64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_8000_0000,
        64'h0000_0000_7FFF_FFFF, 64'h8000_0000_0000_0000,
        64'h7FFF_FFFF_FFFF_FFFF, 64'd31, 64'd32, 64'd63, 64'd64
    };

    initial begin
        op = 5'd0; a = '0; b = '0;
        // reset-state check: all-zero inputs give zero result and flags
        @(negedge clk);
        n_chk++;
        if (res !== 64'd0 || zero !== 1'b1 || lts || ltu) begin
            n_bad++;
            $display("FAIL R9 idle actual=%h/%b expected=0/1", res, zero);
        end
        // R1..R10: every code over the corner cross product
        for (int o = 0; o < 32; o++)
            for (int i = 0; i < 10; i++)
                for (int j = 0; j < 10; j++)
                    apply(5'(o), corners[i], corners[j]);
        // random operands, with shift amounts hitting b[5] (R5 ignores it)
        for (int k = 0; k < 120; k++) begin
            logic [63:0] ra, rb;
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            for (int o = 0; o < 23; o++) apply(5'(o), ra, rb);
        end
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule